// File: doc/BRIEF.md
# Stream Link Benchmark Engine

This block exercises a point-to-point stream link that behaves like a FIFO. Its transmit side writes into the link through a write strobe that is gated by a full flag. Its receive side reads from the link through a read strobe that is gated by an empty flag. A single core can play one of two roles: initiator or responder. It can run one of three tests: throughput, latency or reliability. When a test ends, the core holds its results (an elapsed-cycle count, an error count and the first wrong value) on output ports until a host starts the next run.

As initiator in throughput or reliability mode, the core writes sequence numbers on every cycle the link is not full and times the whole transfer. As initiator in latency mode, it sends one probe word and times the round trip to the single reply.

As responder, the core does one of two things. In latency mode it echoes the one word it receives. In the other two modes it sinks a programmed number of words, and in reliability mode it also checks their sequence.

Top module: `link_bench_core`

## Requirements
- R1: After reset the core is idle: `done`, `busy`, `errSeen`, `cycleCount`, `errCount` are zero and neither `txWrite` nor `rxRead` is asserted, whatever the link flags show.
- R2: `txWrite` is never high while `txFull` is high, and `rxRead` is never high while `rxEmpty` is high.
- R3: An initiator in throughput mode (`modeSel`=0) writes the values 0, 1, 2, … on every non-full cycle until `wordTarget` words are written. `cycleCount` then equals the number of cycles `busy` was high, stalls included, and `done` rises in the cycle after the last write.
- R4: A start with `wordTarget`=0 in throughput or reliability mode performs no transfer. In the next cycle it shows `done`=1, `busy`=0 and `cycleCount`=0.
- R5: An initiator in latency mode (`modeSel`=1) writes exactly one word equal to `LAT_PROBE`, then reads exactly one reply. `cycleCount` equals the read cycle minus the write cycle. A reply different from `LAT_PROBE` counts as one error and is latched in `firstBad`.
- R6: A responder in latency mode accepts one word and returns it unchanged. The return write happens in the cycle after acceptance, or later while `txFull` holds it back. No further word is read while the echo is pending. `done` rises after the echo write.
- R7: A responder in reliability mode (`modeSel`=2) reads `wordTarget` words and expects word k to equal k, whatever came before. Each mismatch raises `errCount` by one and sets `errSeen`. `firstBad` holds the first mismatching value.
- R8: A responder in throughput mode (`modeSel`=0) reads `wordTarget` words without checking their values. `errCount` stays zero.
- R9: `cycleCount` saturates at all-ones instead of wrapping.
- R10: Once `done` is set, `cycleCount`, `errCount` and `firstBad` hold and no link strobe is issued until the next `start`. A `start` pulse clears all results.
- R11: `errCount` saturates at all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: clear results and begin a run |
| roleSel | input | 1 | 0 initiator, 1 responder (captured at start) |
| modeSel | input | 2 | 0 throughput, 1 latency, 2 reliability, 3 as throughput (captured at start) |
| wordTarget | input | CNT_W | Number of words to move (captured at start) |
| txData | output | DW | Word offered to the link |
| txWrite | output | 1 | Write strobe into the link |
| txFull | input | 1 | Link cannot accept a word this cycle |
| rxData | input | DW | Word at the head of the incoming link |
| rxRead | output | 1 | Read strobe from the link |
| rxEmpty | input | 1 | Incoming link holds no word |
| cycleCount | output | CYC_W | Measured cycle count |
| errCount | output | ERR_W | Number of mismatching words |
| errSeen | output | 1 | At least one mismatch since start |
| firstBad | output | DW | First mismatching value |
| done | output | 1 | Run finished, results stable |
| busy | output | 1 | Run in progress |

## Verification
The checker assumes that the link's flags are truthful. It also assumes that `rxData` is meaningful only in cycles where `rxEmpty` is low, and that `start` is a pulse from the host rather than a level. The bench plays the link itself: it changes `txFull`, `rxEmpty` and `rxData` only on the falling edge and samples just after. It leaves `roleSel`, `modeSel` and `wordTarget` untouched between starts. It also presents incoming words only as the patterns described in the requirements (in-order sequences, deliberately wrong values, and delayed replies), so every strobe the design issues is one it may legally issue.

// File: rtl/link_bench_pkg.sv
package link_bench_pkg;

  typedef enum logic [1:0] {
    MODE_THRU = 2'b00,
    MODE_LAT  = 2'b01,
    MODE_REL  = 2'b10,
    MODE_ALT  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    TXSRC_SEQ   = 2'b00,
    TXSRC_PROBE = 2'b01,
    TXSRC_ECHO  = 2'b10
  } txsrc_e;

  typedef enum logic [1:0] {
    CHK_NONE  = 2'b00,
    CHK_SEQ   = 2'b01,
    CHK_PROBE = 2'b10
  } chk_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_WAIT = 3'd2,
    ST_ECHO = 3'd3,
    ST_DONE = 3'd4
  } state_e;

  typedef struct packed {
    logic   clear;
    logic   cycInc;
    logic   cycLoadOne;
    logic   txAdv;
    logic   rxAdv;
    logic   echoLoad;
    chk_e   chkSel;
    txsrc_e txSrc;
  } strobe_t;

endpackage

// File: rtl/link_bench_ctrl.sv
module link_bench_ctrl
  import link_bench_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       roleSel,
  input  logic [1:0] modeSel,
  input  logic       targetIsZero,
  input  logic       txLast,
  input  logic       rxLast,
  input  logic       txFull,
  input  logic       rxEmpty,
  output logic       txWrite,
  output logic       rxRead,
  output strobe_t    stb,
  output logic       done,
  output logic       busy
);

  state_e state, stateNext;
  logic   roleQ;
  mode_e  modeQ;
  logic   isLat, isRel;

  assign isLat = (modeQ == MODE_LAT);
  assign isRel = (modeQ == MODE_REL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      roleQ <= 1'b0;
      modeQ <= MODE_THRU;
    end else begin
      state <= stateNext;
      if (start) begin
        roleQ <= roleSel;
        modeQ <= mode_e'(modeSel);
      end
    end
  end

  always_comb begin
    stb        = '0;
    stb.chkSel = CHK_NONE;
    stb.txSrc  = TXSRC_SEQ;
    txWrite    = 1'b0;
    rxRead     = 1'b0;
    stateNext  = state;

    unique case (state)
      ST_RUN: begin
        if (!roleQ) begin
          if (isLat) begin
            stb.txSrc = TXSRC_PROBE;
            txWrite   = !txFull;
            if (txWrite) begin
              stb.cycLoadOne = 1'b1;
              stateNext      = ST_WAIT;
            end
          end else begin
            stb.txSrc  = TXSRC_SEQ;
            txWrite    = !txFull;
            stb.cycInc = 1'b1;
            stb.txAdv  = txWrite;
            if (txWrite && txLast) stateNext = ST_DONE;
          end
        end else begin
          rxRead     = !rxEmpty;
          stb.cycInc = 1'b1;
          if (isLat) begin
            stb.echoLoad = rxRead;
            if (rxRead) stateNext = ST_ECHO;
          end else begin
            stb.rxAdv = rxRead;
            if (isRel && rxRead) stb.chkSel = CHK_SEQ;
            if (rxRead && rxLast) stateNext = ST_DONE;
          end
        end
      end
      ST_WAIT: begin
        rxRead = !rxEmpty;
        if (rxRead) begin
          stb.chkSel = CHK_PROBE;
          stateNext  = ST_DONE;
        end else begin
          stb.cycInc = 1'b1;
        end
      end
      ST_ECHO: begin
        stb.txSrc  = TXSRC_ECHO;
        txWrite    = !txFull;
        stb.cycInc = 1'b1;
        if (txWrite) stateNext = ST_DONE;
      end
      default: ;
    endcase

    if (start) begin
      stb        = '0;
      stb.clear  = 1'b1;
      stb.chkSel = CHK_NONE;
      stb.txSrc  = TXSRC_SEQ;
      txWrite    = 1'b0;
      rxRead     = 1'b0;
      stateNext  = (targetIsZero && (modeSel != MODE_LAT)) ? ST_DONE : ST_RUN;
    end
  end

  assign done = (state == ST_DONE);
  assign busy = (state == ST_RUN) || (state == ST_WAIT) || (state == ST_ECHO);

endmodule

// File: rtl/link_bench_dp.sv
module link_bench_dp
  import link_bench_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 32,
  parameter int CYC_W = 32,
  parameter int ERR_W = 16,
  parameter logic [DW-1:0] LAT_PROBE = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wordTarget,
  input  logic [DW-1:0]    rxData,
  output logic [DW-1:0]    txData,
  output logic             txLast,
  output logic             rxLast,
  output logic [CYC_W-1:0] cycleCount,
  output logic [ERR_W-1:0] errCount,
  output logic             errSeen,
  output logic [DW-1:0]    firstBad
);

  localparam logic [CYC_W-1:0] CYC_MAX = '1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] targetQ, txSeq, rxSeq;
  logic [DW-1:0]    echoQ;
  logic             mismatch;

  assign txLast = (txSeq == targetQ - CNT_ONE);
  assign rxLast = (rxSeq == targetQ - CNT_ONE);

  always_comb begin
    unique case (stb.chkSel)
      CHK_SEQ:   mismatch = (rxData != DW'(rxSeq));
      CHK_PROBE: mismatch = (rxData != LAT_PROBE);
      default:   mismatch = 1'b0;
    endcase
  end

  always_comb begin
    unique case (stb.txSrc)
      TXSRC_PROBE: txData = LAT_PROBE;
      TXSRC_ECHO:  txData = echoQ;
      default:     txData = DW'(txSeq);
    endcase
  end

  // word indices and captured target
  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= '0;
      txSeq   <= '0;
      rxSeq   <= '0;
      echoQ   <= '0;
    end else if (stb.clear) begin
      targetQ <= wordTarget;
      txSeq   <= '0;
      rxSeq   <= '0;
      echoQ   <= '0;
    end else begin
      if (stb.txAdv)    txSeq <= txSeq + CNT_ONE;
      if (stb.rxAdv)    rxSeq <= rxSeq + CNT_ONE;
      if (stb.echoLoad) echoQ <= rxData;
    end
  end

  // saturating cycle counter
  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      cycleCount <= '0;
    end else if (stb.cycLoadOne) begin
      cycleCount <= CYC_W'(1);
    end else if (stb.cycInc && (cycleCount != CYC_MAX)) begin
      cycleCount <= cycleCount + CYC_W'(1);
    end
  end

  // error tally and first wrong value
  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      errCount <= '0;
      errSeen  <= 1'b0;
      firstBad <= '0;
    end else if (mismatch) begin
      if (errCount != ERR_MAX) errCount <= errCount + ERR_W'(1);
      if (!errSeen) firstBad <= rxData;
      errSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/link_bench_core.sv
module link_bench_core
  import link_bench_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 32,
  parameter int CYC_W = 32,
  parameter int ERR_W = 16,
  parameter logic [DW-1:0] LAT_PROBE = DW'(32'h5A3C_96E1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             roleSel,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] wordTarget,
  output logic [DW-1:0]    txData,
  output logic             txWrite,
  input  logic             txFull,
  input  logic [DW-1:0]    rxData,
  output logic             rxRead,
  input  logic             rxEmpty,
  output logic [CYC_W-1:0] cycleCount,
  output logic [ERR_W-1:0] errCount,
  output logic             errSeen,
  output logic [DW-1:0]    firstBad,
  output logic             done,
  output logic             busy
);

  strobe_t stb;
  logic    txLast, rxLast;

  link_bench_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .roleSel      (roleSel),
    .modeSel      (modeSel),
    .targetIsZero (wordTarget == '0),
    .txLast       (txLast),
    .rxLast       (rxLast),
    .txFull       (txFull),
    .rxEmpty      (rxEmpty),
    .txWrite      (txWrite),
    .rxRead       (rxRead),
    .stb          (stb),
    .done         (done),
    .busy         (busy)
  );

  link_bench_dp #(
    .DW        (DW),
    .CNT_W     (CNT_W),
    .CYC_W     (CYC_W),
    .ERR_W     (ERR_W),
    .LAT_PROBE (LAT_PROBE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wordTarget (wordTarget),
    .rxData     (rxData),
    .txData     (txData),
    .txLast     (txLast),
    .rxLast     (rxLast),
    .cycleCount (cycleCount),
    .errCount   (errCount),
    .errSeen    (errSeen),
    .firstBad   (firstBad)
  );

endmodule

// File: rtl/link_bench_chk.sv
module link_bench_chk #(
  parameter int DW    = 32,
  parameter int CYC_W = 32,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             txWrite,
  input logic             txFull,
  input logic             rxRead,
  input logic             rxEmpty,
  input logic             done,
  input logic             busy,
  input logic [CYC_W-1:0] cycleCount,
  input logic [ERR_W-1:0] errCount,
  input logic             errSeen,
  input logic [DW-1:0]    firstBad
);

  assert_no_write_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |-> !txFull);

  assert_no_read_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxRead |-> !rxEmpty);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  assert_quiet_when_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |-> (!txWrite && !rxRead));

  assert_count_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> $stable(cycleCount) && $stable(errCount));

  assert_first_bad_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errSeen && !start) |=> $stable(firstBad));

  assert_err_rising_R7: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (errCount >= $past(errCount)));

  assert_cycle_saturate_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((&cycleCount) && !start) |=> (&cycleCount));

  assert_err_saturate_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((&errCount) && !start) |=> (&errCount));

endmodule

bind link_bench_core link_bench_chk #(
  .DW    (DW),
  .CYC_W (CYC_W),
  .ERR_W (ERR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .txWrite    (txWrite),
  .txFull     (txFull),
  .rxRead     (rxRead),
  .rxEmpty    (rxEmpty),
  .done       (done),
  .busy       (busy),
  .cycleCount (cycleCount),
  .errCount   (errCount),
  .errSeen    (errSeen),
  .firstBad   (firstBad)
);

// File: tb/link_bench_core_bench.sv
`timescale 1ns/1ps
module link_bench_core_bench;

  localparam int DW    = 16;
  localparam int CNT_W = 16;
  localparam int CYC_W = 10;
  localparam int ERR_W = 3;
  localparam logic [DW-1:0] PROBE = 16'hC3A5;
  localparam logic [CYC_W-1:0] CYC_TOP = '1;
  localparam logic [ERR_W-1:0] ERR_TOP = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic roleSel = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [CNT_W-1:0] wordTarget = '0;
  logic [DW-1:0] txData;
  logic txWrite;
  logic txFull = 1'b1;
  logic [DW-1:0] rxData = '0;
  logic rxRead;
  logic rxEmpty = 1'b1;
  logic [CYC_W-1:0] cycleCount;
  logic [ERR_W-1:0] errCount;
  logic errSeen;
  logic [DW-1:0] firstBad;
  logic done, busy;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [DW-1:0] feedBuf [16];

  always #2.5 clk = ~clk;

  link_bench_core #(
    .DW(DW), .CNT_W(CNT_W), .CYC_W(CYC_W), .ERR_W(ERR_W), .LAT_PROBE(PROBE)
  ) u_link_bench_core (
    .clk(clk), .rstN(rstN), .start(start), .roleSel(roleSel), .modeSel(modeSel),
    .wordTarget(wordTarget), .txData(txData), .txWrite(txWrite), .txFull(txFull),
    .rxData(rxData), .rxRead(rxRead), .rxEmpty(rxEmpty), .cycleCount(cycleCount),
    .errCount(errCount), .errSeen(errSeen), .firstBad(firstBad), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startRun(input logic role, input logic [1:0] mode, input int target);
    @(negedge clk);
    txFull = 1'b1; rxEmpty = 1'b1;
    roleSel = role; modeSel = mode; wordTarget = CNT_W'(target);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic testReset;
    txFull = 1'b0; rxEmpty = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!done && !busy, "R1 idle flags", {done, busy}, 0);
    check(cycleCount == 0 && errCount == 0 && !errSeen, "R1 results zero", cycleCount, 0);
    check(!txWrite && !rxRead, "R1 no strobes", {txWrite, rxRead}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!txWrite && !rxRead && !busy, "R1 idle after release", {txWrite, rxRead, busy}, 0);
  endtask

  task automatic testThroughput(input int target, input int stallPeriod);
    int seq = 0;
    int busyCycles = 0;
    startRun(1'b0, 2'd0, target);
    for (int c = 0; c < 500; c++) begin
      txFull = (stallPeriod != 0) && (c % stallPeriod == 1);
      #1;
      if (!busy) break;
      busyCycles++;
      check(txWrite == !txFull, "R2 R3 write follows not-full", txWrite, !txFull);
      if (txWrite) begin
        check(txData == DW'(seq), "R3 sequence value", txData, seq);
        seq++;
      end
      @(negedge clk);
    end
    check(done, "R3 done raised", done, 1);
    check(seq == target, "R3 words written", seq, target);
    check(cycleCount == CYC_W'(busyCycles), "R3 cycle count", cycleCount, busyCycles);
  endtask

  task automatic testZeroTarget;
    startRun(1'b0, 2'd2, 0);
    txFull = 1'b0; rxEmpty = 1'b0;
    #1;
    check(done && !busy, "R4 immediate done", {done, busy}, 2);
    check(cycleCount == 0, "R4 zero count", cycleCount, 0);
    check(!txWrite && !rxRead, "R4 no transfer", {txWrite, rxRead}, 0);
  endtask

  task automatic testLatency(input int delay, input logic [DW-1:0] reply,
                             input int expCount, input int expErr);
    startRun(1'b0, 2'd1, 5);
    for (int c = 0; c < 2; c++) begin
      txFull = 1'b1; #1;
      check(!txWrite, "R5 held while full", txWrite, 0);
      @(negedge clk);
    end
    txFull = 1'b0; #1;
    check(txWrite && txData == PROBE, "R5 probe written", txData, PROBE);
    @(negedge clk);
    for (int c = 0; c < delay; c++) begin
      rxEmpty = 1'b1; #1;
      if (c < 4) check(!txWrite && !rxRead, "R5 single word only", {txWrite, rxRead}, 0);
      @(negedge clk);
    end
    rxEmpty = 1'b0; rxData = reply; #1;
    check(rxRead, "R5 reply read", rxRead, 1);
    @(negedge clk);
    rxEmpty = 1'b1; #1;
    check(done, "R5 done after reply", done, 1);
    check(cycleCount == CYC_W'(expCount), "R5 R9 round trip count", cycleCount, expCount);
    check(errCount == ERR_W'(expErr), "R5 reply error count", errCount, expErr);
    if (expErr != 0) check(firstBad == reply, "R5 wrong reply latched", firstBad, reply);
  endtask

  task automatic testEcho;
    startRun(1'b1, 2'd1, 0);
    for (int c = 0; c < 2; c++) begin
      rxEmpty = 1'b1; txFull = 1'b0; #1;
      check(!rxRead && !txWrite, "R6 idle while empty", {rxRead, txWrite}, 0);
      @(negedge clk);
    end
    rxEmpty = 1'b0; rxData = 16'hBEEF; #1;
    check(rxRead && !txWrite, "R6 accept word", {rxRead, txWrite}, 2);
    @(negedge clk);
    rxData = 16'h1111; txFull = 1'b1; #1;
    check(!rxRead && !txWrite, "R6 wait on full", {rxRead, txWrite}, 0);
    @(negedge clk);
    txFull = 1'b0; #1;
    check(txWrite && !rxRead, "R6 echo write", {txWrite, rxRead}, 2);
    check(txData == 16'hBEEF, "R6 echo unchanged", txData, 16'hBEEF);
    @(negedge clk); #1;
    check(done, "R6 done after echo", done, 1);
    check(cycleCount == 5, "R6 cycle count", cycleCount, 5);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      txFull = c[0]; rxEmpty = c[1]; #1;
      check(done && !txWrite && !rxRead && cycleCount == 5, "R10 held after done",
            cycleCount, 5);
    end
  endtask

  task automatic feedSink(input logic [1:0] mode, input int n, input bit gaps);
    int idx = 0;
    startRun(1'b1, mode, n);
    for (int c = 0; c < 200; c++) begin
      rxEmpty = gaps && (c % 2 == 1);
      if (!rxEmpty) rxData = feedBuf[idx];
      #1;
      if (!busy) break;
      check(rxRead == !rxEmpty, "R2 read follows not-empty", rxRead, !rxEmpty);
      if (rxRead) idx++;
      @(negedge clk);
    end
    check(done && idx == n, "R7 R8 words consumed", idx, n);
  endtask

  task automatic testReliability;
    feedBuf[0] = 0; feedBuf[1] = 1; feedBuf[2] = 16'h0007;
    feedBuf[3] = 3; feedBuf[4] = 4; feedBuf[5] = 16'h0009;
    feedSink(2'd2, 6, 1'b1);
    check(errCount == 2, "R7 mismatch count", errCount, 2);
    check(errSeen, "R7 error flag", errSeen, 1);
    check(firstBad == 16'h0007, "R7 first bad value", firstBad, 7);
  endtask

  task automatic testClearOnStart;
    startRun(1'b1, 2'd0, 2);
    rxEmpty = 1'b1; #1;
    check(busy && !done, "R10 restart busy", {busy, done}, 2);
    check(errCount == 0 && !errSeen && cycleCount == 0 && firstBad == 0,
          "R10 results cleared", errCount, 0);
    @(negedge clk);
    feedBuf[0] = 16'h5555; feedBuf[1] = 16'hAAAA;
    feedSink(2'd0, 2, 1'b0);
    check(errCount == 0 && !errSeen, "R8 no checking in sink", errCount, 0);
  endtask

  task automatic testErrSaturate;
    for (int i = 0; i < 16; i++) feedBuf[i] = 16'hFFFF;
    feedSink(2'd2, 10, 1'b0);
    check(errCount == ERR_TOP, "R11 error count saturates", errCount, ERR_TOP);
  endtask

  initial begin
    testReset();
    testThroughput(5, 0);
    testThroughput(7, 3);
    testZeroTarget();
    testLatency(4, PROBE, 5, 0);
    testLatency(2, 16'h1234, 3, 1);
    testLatency(1100, PROBE, int'(CYC_TOP), 0);
    testEcho();
    testReliability();
    testClearOnStart();
    testErrSaturate();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule